// File: doc/BRIEF.md
# Environment Configuration Register with FENCE Widening

This block holds the machine-level environment configuration that governs how the less privileged modes run. It has a small CSR port: an address, an access enable, a write enable and write data go in, and the selected register comes back combinationally on the read data. The cache-block, timer and zeroing enables are stored and exposed on their own output ports for the logic that implements those features. The block implements none of those features itself.

The block also takes the predecessor and successor sets of a decoded FENCE, split into a 4-bit device I/O set and a 4-bit memory set, together with the privilege of the issuing hart. It returns the effective 8-bit ordering set. When the I/O-implies-memory control bit is set and the fence does not come from machine mode, each device I/O ordering bit also turns on the matching memory ordering bit.

The `XLEN` parameter selects a 64-bit build or a 32-bit build. In the 32-bit build the upper half of the register is reached through a second address. `HAS_UMODE` = 0 builds a core without user mode, and in that build the control bit is tied to zero.

Top module: `envcfg_ctrl`

## Requirements
- R1: On reset (asynchronous, active-low `rst_n`), all stored fields go to zero. Both registers then read as zero and every field output is low.
- R2: In the 64-bit layout the control bit is at bit 0, the 2-bit cache-block invalidate enable at bits 5:4, the cache-block clean/flush enable at bit 6, the zeroing enable at bit 7, and the timer-compare enable at bit 63. A write at the low address (`ADDR_LO`, default 0x30A) with `csr_en`=1 and `csr_we`=1 shows on the field ports and the read data from the next rising clock edge. A read is combinational from the stored value.
- R3: Reserved positions (bits 3:1 and every bit from 8 up to the top bit) always read as zero. Writes to them are discarded.
- R4: `fence_io` is {PI,PO,SI,SO} (bit 3 down to 0), `fence_mem` is {PR,PW,SR,SW}, and `fence_eff` is {PI,PO,PR,PW,SI,SO,SR,SW} (bit 7 down to 0). When the control bit is 1 and `priv` is not 2'b11, PI also sets PR and PO also sets PW.
- R5: Under the same conditions, SI also sets SR and SO also sets SW.
- R6: When `priv` is 2'b11 (machine mode), or when the control bit is 0, `fence_eff` is the inputs passed through unchanged. Widening never clears a bit.
- R7: With `HAS_UMODE`=0, the control bit reads 0, writes to it are ignored, and fences are never widened.
- R8: With `XLEN`=32, the low address holds bits 31:0 of the layout. The high address (`ADDR_HI`, default 0x31A) holds bits 63:32, so the timer-compare enable sits at its bit 31.
- R9: With `XLEN`=64, an access at the high address raises `csr_illegal`, reads as zero, does not raise `csr_hit`, and writes there leave the state unchanged.
- R10: Nothing changes when `csr_en` is 0 or `csr_we` is 0, or when the address matches neither register. `csr_hit` is raised only for an enabled access to an implemented register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | CSR access strobe |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data of the addressed register, zero otherwise |
| csr_hit | output | 1 | Access targets an implemented register |
| csr_illegal | output | 1 | Access targets the high address in a 64-bit build |
| priv | input | 2 | Privilege of the fence: 00 user, 01 supervisor, 11 machine |
| fence_io | input | 4 | Device I/O set {PI,PO,SI,SO} |
| fence_mem | input | 4 | Memory set {PR,PW,SR,SW} |
| fence_eff | output | 8 | Effective set {PI,PO,PR,PW,SI,SO,SR,SW} |
| cfg_fiom | output | 1 | I/O-implies-memory control bit |
| cfg_cbie | output | 2 | Cache-block invalidate enable |
| cfg_cbcfe | output | 1 | Cache-block clean/flush enable |
| cfg_cbze | output | 1 | Cache-block zeroing enable |
| cfg_stcd | output | 1 | Timer-compare enable |

## Verification
The bench sweeps all 256 fence input combinations under all four privilege codes, with the control bit set and with it clear. A design that also widened machine-mode fences, or paired PI with PW instead of PR, would miscompare there. Three instances are checked side by side: a 64-bit build, a 32-bit build and a build without user mode. A layout that put the timer enable in the wrong half, accepted high-address writes in the 64-bit build, or let the tied control bit be written would show up as wrong read data or wrong field ports. Random writes with all ones in the reserved bits, writes with the strobe low, and writes to unrelated addresses catch reserved bits that stick and updates that escape their enable.

// File: rtl/envcfg_pkg.sv
package envcfg_pkg;

  typedef struct packed {
    logic       stcd;
    logic       cbze;
    logic       cbcfe;
    logic [1:0] cbie;
    logic       fiom;
  } envcfg_t;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  localparam int unsigned IMG_W       = 64;
  localparam int unsigned POS_FIOM    = 0;
  localparam int unsigned POS_CBIE_LO = 4;
  localparam int unsigned POS_CBCFE   = 6;
  localparam int unsigned POS_CBZE    = 7;
  localparam int unsigned POS_STCD    = 63;
  localparam int unsigned SET_PAIRS   = 2;  // predecessor, successor

  // Full 64-bit image of the stored fields; reserved bits stay zero.
  function automatic logic [IMG_W-1:0] cfg_to_image(envcfg_t c);
    logic [IMG_W-1:0] img;
    img                            = '0;
    img[POS_FIOM]                  = c.fiom;
    img[POS_CBIE_LO+1:POS_CBIE_LO] = c.cbie;
    img[POS_CBCFE]                 = c.cbcfe;
    img[POS_CBZE]                  = c.cbze;
    img[POS_STCD]                  = c.stcd;
    return img;
  endfunction

endpackage

// File: rtl/envcfg_csr_decode.sv
module envcfg_csr_decode #(
  parameter int unsigned      XLEN    = 64,
  parameter logic [11:0]      ADDR_LO = 12'h30A,
  parameter logic [11:0]      ADDR_HI = 12'h31A
) (
  input  logic        csr_en,
  input  logic        csr_we,
  input  logic [11:0] csr_addr,
  output logic        rd_lo,
  output logic        rd_hi,
  output logic        wr_lo,
  output logic        wr_hi,
  output logic        hit,
  output logic        illegal
);

  logic sel_lo, sel_hi;

  assign sel_lo = csr_en && (csr_addr == ADDR_LO);
  assign sel_hi = csr_en && (csr_addr == ADDR_HI);
  assign rd_lo  = sel_lo;
  assign wr_lo  = sel_lo && csr_we;

  generate
    if (XLEN == 32) begin : g_split
      assign rd_hi   = sel_hi;
      assign wr_hi   = sel_hi && csr_we;
      assign hit     = sel_lo || sel_hi;
      assign illegal = 1'b0;
    end else begin : g_wide
      assign rd_hi   = 1'b0;
      assign wr_hi   = 1'b0;
      assign hit     = sel_lo;
      assign illegal = sel_hi;
    end
  endgenerate

endmodule

// File: rtl/envcfg_regs.sv
module envcfg_regs
  import envcfg_pkg::*;
#(
  parameter int unsigned XLEN      = 64,
  parameter bit          HAS_UMODE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_lo,
  input  logic            rd_hi,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [XLEN-1:0] wdata,
  output envcfg_t         cfg,
  output logic [XLEN-1:0] rdata
);

  localparam bit STCD_IN_LO = (XLEN == IMG_W);
  localparam int unsigned TOP = XLEN - 1;

  envcfg_t          cfg_q, cfg_d;
  logic             cfg_en;
  logic [IMG_W-1:0] image;

  assign cfg_en = wr_lo || wr_hi;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_lo) begin
      cfg_d.fiom  = HAS_UMODE ? wdata[POS_FIOM] : 1'b0;
      cfg_d.cbie  = wdata[POS_CBIE_LO+1:POS_CBIE_LO];
      cfg_d.cbcfe = wdata[POS_CBCFE];
      cfg_d.cbze  = wdata[POS_CBZE];
      if (STCD_IN_LO) cfg_d.stcd = wdata[TOP];
    end
    if (wr_hi) begin
      cfg_d.stcd = wdata[TOP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign image = cfg_to_image(cfg_q);
  assign cfg   = cfg_q;

  always_comb begin
    rdata = '0;
    if (rd_lo)      rdata = image[XLEN-1:0];
    else if (rd_hi) rdata = image[IMG_W-1 -: XLEN];
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo || wr_hi) |=> $stable(cfg_q));

  p_cbie_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cfg_q.cbie == $past(wdata[POS_CBIE_LO+1:POS_CBIE_LO]));

  p_resv_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |-> (rdata[3:1] == 3'b000) && (rdata[TOP-1:8] == '0));

  generate
    if (!HAS_UMODE) begin : g_no_umode
      p_fiom_tied_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && wdata[POS_FIOM]) |=> !cfg_q.fiom);
    end
    if (XLEN != IMG_W) begin : g_hi_chk
      p_hi_only_stcd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> $stable(cfg_q.cbie) && $stable(cfg_q.fiom));
    end
  endgenerate

endmodule

// File: rtl/envcfg_fence_widen.sv
module envcfg_fence_widen
  import envcfg_pkg::*;
(
  input  logic       fiom,
  input  logic [1:0] priv,
  input  logic [3:0] fence_io,
  input  logic [3:0] fence_mem,
  output logic [7:0] fence_eff
);

  logic widen;

  assign widen = fiom && (priv != PRIV_M);

  // Pair k=1 is the predecessor set, k=0 the successor set.
  generate
    for (genvar k = 0; k < SET_PAIRS; k++) begin : g_pair
      assign fence_eff[4*k+3] = fence_io[2*k+1];
      assign fence_eff[4*k+2] = fence_io[2*k];
      assign fence_eff[4*k+1] = fence_mem[2*k+1] | (widen & fence_io[2*k+1]);
      assign fence_eff[4*k]   = fence_mem[2*k]   | (widen & fence_io[2*k]);
    end
  endgenerate

endmodule

// File: rtl/envcfg_ctrl.sv
module envcfg_ctrl
  import envcfg_pkg::*;
#(
  parameter int unsigned XLEN      = 64,
  parameter bit          HAS_UMODE = 1'b1,
  parameter logic [11:0] ADDR_LO   = 12'h30A,
  parameter logic [11:0] ADDR_HI   = 12'h31A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_en,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_hit,
  output logic            csr_illegal,
  input  logic [1:0]      priv,
  input  logic [3:0]      fence_io,
  input  logic [3:0]      fence_mem,
  output logic [7:0]      fence_eff,
  output logic            cfg_fiom,
  output logic [1:0]      cfg_cbie,
  output logic            cfg_cbcfe,
  output logic            cfg_cbze,
  output logic            cfg_stcd
);

  logic    rd_lo, rd_hi, wr_lo, wr_hi;
  envcfg_t cfg;

  envcfg_csr_decode #(
    .XLEN(XLEN), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
  ) u_decode (
    .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .hit(csr_hit), .illegal(csr_illegal)
  );

  envcfg_regs #(
    .XLEN(XLEN), .HAS_UMODE(HAS_UMODE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(csr_wdata), .cfg(cfg), .rdata(csr_rdata)
  );

  envcfg_fence_widen u_fence (
    .fiom(cfg.fiom), .priv(priv),
    .fence_io(fence_io), .fence_mem(fence_mem), .fence_eff(fence_eff)
  );

  assign cfg_fiom  = cfg.fiom;
  assign cfg_cbie  = cfg.cbie;
  assign cfg_cbcfe = cfg.cbcfe;
  assign cfg_cbze  = cfg.cbze;
  assign cfg_stcd  = cfg.stcd;

  p_mpass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_M) |->
      fence_eff == {fence_io[3:2], fence_mem[3:2], fence_io[1:0], fence_mem[1:0]});

  p_superset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((fence_eff & {fence_io[3:2], fence_mem[3:2], fence_io[1:0], fence_mem[1:0]})
      == {fence_io[3:2], fence_mem[3:2], fence_io[1:0], fence_mem[1:0]}));

  p_pred_widen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fiom && priv != PRIV_M && fence_io[3]) |-> fence_eff[5]);

  p_succ_widen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fiom && priv != PRIV_M && fence_io[0]) |-> fence_eff[0]);

  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0) && !csr_hit);

  p_illegal_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_illegal && csr_we) |=> $stable(cfg_stcd) && $stable(cfg_cbie));

endmodule

// File: tb/envcfg_ctrl_tb_top.sv
module envcfg_ctrl_tb_top;

  localparam logic [11:0] A_LO  = 12'h30A;
  localparam logic [11:0] A_HI  = 12'h31A;
  localparam logic [11:0] A_OTH = 12'h300;
  localparam logic [63:0] M64   = 64'h8000_0000_0000_00F1;
  localparam logic [63:0] MNOU  = 64'h8000_0000_0000_00F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        en = 1'b0, we = 1'b0;
  logic [11:0] addr = 12'h0;
  logic [63:0] wd = '0;
  logic [1:0]  priv = 2'b0;
  logic [3:0]  fio = '0, fmem = '0;

  logic [63:0] rd64, rdn;
  logic [31:0] rd32;
  logic        hit64, ill64, hitn, illn, hit32, ill32;
  logic [7:0]  fe64, fen, fe32;
  logic        f64, fn, f32, z64, zn, z32, c64, cn, c32, s64, sn, s32;
  logic [1:0]  i64, in_, i32;

  envcfg_ctrl #(.XLEN(64), .HAS_UMODE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_en(en), .csr_we(we), .csr_addr(addr),
    .csr_wdata(wd), .csr_rdata(rd64), .csr_hit(hit64), .csr_illegal(ill64),
    .priv(priv), .fence_io(fio), .fence_mem(fmem), .fence_eff(fe64),
    .cfg_fiom(f64), .cfg_cbie(i64), .cfg_cbcfe(c64), .cfg_cbze(z64), .cfg_stcd(s64));

  envcfg_ctrl #(.XLEN(32), .HAS_UMODE(1'b1)) dut32_i (
    .clk(clk), .rst_n(rst_n), .csr_en(en), .csr_we(we), .csr_addr(addr),
    .csr_wdata(wd[31:0]), .csr_rdata(rd32), .csr_hit(hit32), .csr_illegal(ill32),
    .priv(priv), .fence_io(fio), .fence_mem(fmem), .fence_eff(fe32),
    .cfg_fiom(f32), .cfg_cbie(i32), .cfg_cbcfe(c32), .cfg_cbze(z32), .cfg_stcd(s32));

  envcfg_ctrl #(.XLEN(64), .HAS_UMODE(1'b0)) dutn_i (
    .clk(clk), .rst_n(rst_n), .csr_en(en), .csr_we(we), .csr_addr(addr),
    .csr_wdata(wd), .csr_rdata(rdn), .csr_hit(hitn), .csr_illegal(illn),
    .priv(priv), .fence_io(fio), .fence_mem(fmem), .fence_eff(fen),
    .cfg_fiom(fn), .cfg_cbie(in_), .cfg_cbcfe(cn), .cfg_cbze(zn), .cfg_stcd(sn));

  int unsigned nvec = 0, nfail = 0;
  logic [63:0] e64 = '0, en_ = '0;
  logic [31:0] e32lo = '0, e32hi = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fence_model(logic [3:0] io, logic [3:0] mem, logic w);
    return {io[3], io[2], mem[3] | (w & io[3]), mem[2] | (w & io[2]),
            io[1], io[0], mem[1] | (w & io[1]), mem[0] | (w & io[0])};
  endfunction

  task automatic check_fields(input string req);
    chk({req, " 64 fields"}, {59'b0, s64, z64, c64, i64, f64},
        {59'b0, e64[63], e64[7], e64[6], e64[5:4], e64[0]});
    chk({req, " nou fields"}, {59'b0, sn, zn, cn, in_, fn},
        {59'b0, en_[63], en_[7], en_[6], en_[5:4], en_[0]});
    chk({req, " 32 fields"}, {59'b0, s32, z32, c32, i32, f32},
        {59'b0, e32hi[31], e32lo[7], e32lo[6], e32lo[5:4], e32lo[0]});
  endtask

  // One CSR access, started just after a falling edge.
  task automatic csr_op(input logic [11:0] a, input logic e, input logic w,
                        input logic [63:0] d, input string req);
    addr = a; en = e; we = w; wd = d;
    #1;
    if (e && a == A_LO) begin
      chk({req, " R2 rd64"}, rd64, e64);
      chk({req, " R7 rdnou"}, rdn, en_);
      chk({req, " R8 rd32lo"}, {32'b0, rd32}, {32'b0, e32lo});
    end else if (e && a == A_HI) begin
      chk({req, " R9 illegal"}, {62'b0, ill64, hit64}, 64'b10);
      chk({req, " R9 rd64 zero"}, rd64, 64'b0);
      chk({req, " R8 rd32hi"}, {31'b0, hit32, rd32}, {31'b0, 1'b1, e32hi});
    end else begin
      chk({req, " R10 nohit"}, {61'b0, hit64, hit32, ill64}, 64'b0);
    end
    @(posedge clk);
    if (e && w && a == A_LO) begin
      e64 = d & M64; en_ = d & MNOU; e32lo = d[31:0] & 32'h0000_00F1;
    end
    if (e && w && a == A_HI) e32hi = d[31:0] & 32'h8000_0000;
    @(negedge clk);
    en = 1'b0; we = 1'b0;
    check_fields(req);
  endtask

  initial begin : watchdog
    #2_000_000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_fields("R1 reset");
    csr_op(A_LO, 1'b1, 1'b0, 64'h0, "R1 reset read");
    csr_op(A_HI, 1'b1, 1'b0, 64'h0, "R1 reset read hi");
    // R3 all ones, reserved bits must drop
    csr_op(A_LO, 1'b1, 1'b1, '1, "R3 ones");
    csr_op(A_LO, 1'b1, 1'b0, 64'h0, "R3 readback");
    // R9 high write in the 64-bit build must not touch it
    csr_op(A_HI, 1'b1, 1'b1, 64'h0, "R9 hi write");
    csr_op(A_HI, 1'b1, 1'b0, 64'h0, "R9 hi read");
    csr_op(A_LO, 1'b1, 1'b0, 64'h0, "R9 lo intact");
    // R10 strobe low / other address
    csr_op(A_LO, 1'b0, 1'b1, 64'h0, "R10 en low");
    csr_op(A_OTH, 1'b1, 1'b1, 64'h0, "R10 other addr");
    // R7 control bit write with no user mode
    csr_op(A_LO, 1'b1, 1'b1, 64'h1, "R7 fiom write");
    chk("R7 fiom tied", {63'b0, fn}, 64'b0);

    for (int n = 0; n < 400; n++) begin
      logic [1:0]  pick;
      logic [11:0] a;
      pick = 2'($urandom % 3);
      a = (pick == 0) ? A_LO : (pick == 1) ? A_HI : A_OTH;
      csr_op(a, ($urandom % 4) != 0, 1'($urandom), {$urandom, $urandom}, "R2 rand");
    end

    // Fence sweep: all privilege codes, control bit clear and set.
    for (int f = 0; f < 2; f++) begin
      csr_op(A_LO, 1'b1, 1'b1, 64'(f), "R4 set fiom");
      for (int p = 0; p < 4; p++) begin
        for (int c = 0; c < 256; c++) begin
          logic w;
          priv = 2'(p); fio = c[7:4]; fmem = c[3:0];
          #1;
          w = (f == 1) && (p != 3);
          chk("R4 R5 R6 fence64", {56'b0, fe64}, {56'b0, fence_model(c[7:4], c[3:0], w)});
          chk("R4 R5 R6 fence32", {56'b0, fe32}, {56'b0, fence_model(c[7:4], c[3:0], w)});
          chk("R7 fence nou", {56'b0, fen}, {56'b0, fence_model(c[7:4], c[3:0], 1'b0)});
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule